// File: doc/BRIEF.md
# Buffered Memory Request Crossbar

This block switches memory request packets from a set of processor-side ports to a set of memory-bank ports. Each processor port feeds a seven-entry queue. A packet is one destination bank index plus a payload. Only the oldest packet in each queue can move. Each cycle, every bank port picks at most one of the queue heads aimed at it, using its own round-robin pointer. It then copies that packet into a seven-entry bank buffer. The buffer is drained by the bank through a valid/ready port.

Backpressure works at two points. A full processor queue drops its ready line, which stalls the issuing pipeline. A full bank buffer stops all transfers to that bank, so any queue whose head targets the bank stays frozen. Each bank port is built as one of two variants. An SRAM port can hand over a request every cycle. A DRAM port models one subbank: after each handover it stays silent long enough that requests leave at most once per `DRAM_GAP` cycles. A pending request waits in the buffer until then.

Top module: `mem_xbar`

## Requirements
- R1: Each processor queue holds 7 packets. `in_ready[i]` is low exactly when queue i is full, and a packet is accepted only in a cycle where `in_valid[i]` and `in_ready[i]` are both high.
- R2: Every accepted packet leaves exactly once, on the bank port named by its `in_dest` value, with its payload unchanged. `out_src` gives the index of the processor port it entered on. Packets from one processor port to one bank port keep their order.
- R3: Each bank port takes at most one packet per cycle. When several queue heads target the same bank, the winner is the first requester found when scanning upward, with wraparound, from the port's pointer. The pointer starts at 0 after reset and moves to one past the last winner. Three ports contending continuously are therefore served in the order 0, 1, 2, 0, 1, 2, ...
- R4: Each bank buffer holds 7 packets. While it is full, no packet is moved into it, and no queue whose head targets it is popped.
- R5: Blocking is head-of-line. A packet behind a blocked head in the same queue does not move, even if its own bank is free. Other queues keep flowing.
- R6: An SRAM bank port (bit clear in `DRAM_MASK`) with a backlog and `out_ready` held high hands over one packet every cycle.
- R7: A DRAM bank port (bit set in `DRAM_MASK`) keeps `out_valid` low for `DRAM_GAP`-1 cycles after each handover. With a backlog and `out_ready` held high, handovers are exactly `DRAM_GAP` cycles apart.
- R8: After reset, all queues and buffers are empty: `in_ready` is all ones and `out_valid` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | N_IN | Request valid, one bit per processor port |
| in_ready | output | N_IN | Queue has room, one bit per processor port |
| in_dest | input | N_IN*DEST_W | Destination bank index per processor port |
| in_payload | input | N_IN*PAY_W | Request payload per processor port |
| out_valid | output | N_OUT | Bank buffer offers a packet that the bank may take now |
| out_ready | input | N_OUT | Bank takes the offered packet |
| out_src | output | N_OUT*SRC_W | Processor port index of the offered packet |
| out_payload | output | N_OUT*PAY_W | Payload of the offered packet |

## Verification
The embedded properties assume two things about the ports. First, a processor port keeps its packet steady until the handshake completes. Second, every destination index names an existing bank. A bank's ready line is free to toggle at any time. The stimulus meets both assumptions: a send task raises valid with a legal index and holds it until it sees ready, and the SRAM ready lines are toggled on a fixed pattern during the mixed-traffic phase. The stimulus also fills queues on purpose by holding a DRAM port's ready low. This drives the full-buffer and head-of-line states that the properties watch.

// File: rtl/mxb_pkg.sv
package mxb_pkg;
   // width of an index able to address n items, never below one bit
   function automatic int unsigned idx_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/mxb_fifo.sv
module mxb_fifo #(
   parameter int unsigned W     = 8,
   parameter int unsigned DEPTH = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         full,
   output logic         empty
);
   import mxb_pkg::*;
   localparam int unsigned PW = idx_w(DEPTH);
   localparam int unsigned CW = $clog2(DEPTH + 1);

   initial assert (DEPTH >= 2) else $error("mxb_fifo: DEPTH must be at least 2");

   logic [W-1:0]  store [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr;
   logic [CW-1:0] fill;

   assign full  = (fill == CW'(DEPTH));
   assign empty = (fill == '0);
   assign dout  = store[rd_ptr];

   always_ff @(posedge clk) begin
      if (push) store[wr_ptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         fill   <= '0;
      end else begin
         if (push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         if (pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
         case ({push, pop})
            2'b10:   fill <= fill + 1'b1;
            2'b01:   fill <= fill - 1'b1;
            default: fill <= fill;
         endcase
      end
   end

   AST_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);  // R1
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);  // R2
endmodule

// File: rtl/mxb_rr_arb.sv
module mxb_rr_arb #(
   parameter int unsigned N = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [N-1:0]                req,
   input  logic                        en,
   output logic [N-1:0]                gnt,
   output logic [mxb_pkg::idx_w(N)-1:0] win
);
   import mxb_pkg::*;
   localparam int unsigned IW = idx_w(N);

   logic [IW-1:0] ptr;
   logic          found;

   always_comb begin
      gnt   = '0;
      win   = '0;
      found = 1'b0;
      for (int k = 0; k < int'(N); k++) begin
         if (en && !found && req[(int'(ptr) + k) % int'(N)]) begin
            gnt[(int'(ptr) + k) % int'(N)] = 1'b1;
            win   = IW'((int'(ptr) + k) % int'(N));
            found = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     ptr <= '0;
      else if (found) ptr <= (win == IW'(N - 1)) ? '0 : win + 1'b1;
   end

   AST_GNT_ONEHOT:  assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt));        // R3
   AST_GNT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n) (gnt & ~req) == '0);   // R3
   AST_GNT_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n) !en |-> gnt == '0);    // R4
endmodule

// File: rtl/mxb_bank_port.sv
module mxb_bank_port #(
   parameter int unsigned SRC_W   = 2,
   parameter int unsigned PAY_W   = 16,
   parameter int unsigned DEPTH   = 7,
   parameter bit          IS_DRAM = 1'b0,
   parameter int unsigned GAP     = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [SRC_W-1:0] wsrc,
   input  logic [PAY_W-1:0] wpay,
   output logic             full,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [SRC_W-1:0] out_src,
   output logic [PAY_W-1:0] out_payload
);
   localparam int unsigned EW = SRC_W + PAY_W;

   initial assert (GAP >= 2) else $error("mxb_bank_port: GAP must be at least 2");

   logic          empty, take, idle;
   logic [EW-1:0] head;

   mxb_fifo #(.W(EW), .DEPTH(DEPTH)) u_buf (
      .clk(clk), .rst_n(rst_n),
      .push(wr), .din({wsrc, wpay}),
      .pop(take), .dout(head),
      .full(full), .empty(empty)
   );

   assign out_valid              = !empty && idle;
   assign take                   = out_valid && out_ready;
   assign {out_src, out_payload} = head;

   generate
      if (IS_DRAM) begin : g_dram
         localparam int unsigned CW = $clog2(GAP);
         logic [CW-1:0] busy;
         always_ff @(posedge clk) begin
            if (!rst_n)         busy <= '0;
            else if (take)      busy <= CW'(GAP - 1);
            else if (busy != 0) busy <= busy - 1'b1;
         end
         assign idle = (busy == '0);

         AST_DRAM_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
            take |=> !out_valid);  // R7
      end else begin : g_sram
         assign idle = 1'b1;
      end
   endgenerate

   AST_FULL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) full |-> !wr);  // R4
   AST_OFFER_HOLDS:   assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_payload) && $stable(out_src));  // R2
endmodule

// File: rtl/mem_xbar.sv
module mem_xbar #(
   parameter int unsigned N_IN       = 4,
   parameter int unsigned N_OUT      = 4,
   parameter int unsigned PAY_W      = 16,
   parameter int unsigned FIFO_DEPTH = 7,
   parameter int unsigned BUF_DEPTH  = 7,
   parameter int unsigned DRAM_GAP   = 32,
   parameter int unsigned DRAM_MASK  = 32'h0000_000C,
   parameter int unsigned DEST_W     = mxb_pkg::idx_w(N_OUT),
   parameter int unsigned SRC_W      = mxb_pkg::idx_w(N_IN)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [N_IN-1:0]          in_valid,
   output logic [N_IN-1:0]          in_ready,
   input  logic [N_IN*DEST_W-1:0]   in_dest,
   input  logic [N_IN*PAY_W-1:0]    in_payload,
   output logic [N_OUT-1:0]         out_valid,
   input  logic [N_OUT-1:0]         out_ready,
   output logic [N_OUT*SRC_W-1:0]   out_src,
   output logic [N_OUT*PAY_W-1:0]   out_payload
);
   localparam int unsigned QW = DEST_W + PAY_W;

   initial assert (N_IN >= 2 && N_OUT >= 2 && N_OUT <= 32)
      else $error("mem_xbar: port counts out of range");

   logic [N_IN-1:0]   hv, in_full, in_pop;
   logic [DEST_W-1:0] hd_dest [N_IN];
   logic [PAY_W-1:0]  hd_pay  [N_IN];
   logic [N_IN-1:0]   gnt_all [N_OUT];

   // processor-side queues
   for (genvar i = 0; i < int'(N_IN); i++) begin : g_in
      logic          emp;
      logic [QW-1:0] hd;
      mxb_fifo #(.W(QW), .DEPTH(FIFO_DEPTH)) u_q (
         .clk(clk), .rst_n(rst_n),
         .push(in_valid[i] && !in_full[i]),
         .din({in_dest[i*DEST_W +: DEST_W], in_payload[i*PAY_W +: PAY_W]}),
         .pop(in_pop[i]), .dout(hd),
         .full(in_full[i]), .empty(emp)
      );
      assign hv[i]                  = !emp;
      assign {hd_dest[i], hd_pay[i]} = hd;
      assign in_ready[i]            = !in_full[i];
   end

   // an input is popped when the bank its head names grants it
   always_comb begin
      for (int i = 0; i < int'(N_IN); i++) begin
         in_pop[i] = 1'b0;
         for (int o = 0; o < int'(N_OUT); o++) in_pop[i] = in_pop[i] | gnt_all[o][i];
      end
   end

   // bank-side arbitration and buffers
   for (genvar o = 0; o < int'(N_OUT); o++) begin : g_out
      logic [N_IN-1:0]  req;
      logic [SRC_W-1:0] win;
      logic             bfull;

      always_comb begin
         for (int i = 0; i < int'(N_IN); i++) req[i] = hv[i] && (hd_dest[i] == DEST_W'(o));
      end

      mxb_rr_arb #(.N(N_IN)) u_arb (
         .clk(clk), .rst_n(rst_n),
         .req(req), .en(!bfull),
         .gnt(gnt_all[o]), .win(win)
      );

      mxb_bank_port #(
         .SRC_W(SRC_W), .PAY_W(PAY_W), .DEPTH(BUF_DEPTH),
         .IS_DRAM(((DRAM_MASK >> o) & 1) == 1), .GAP(DRAM_GAP)
      ) u_port (
         .clk(clk), .rst_n(rst_n),
         .wr(|gnt_all[o]), .wsrc(win), .wpay(hd_pay[win]),
         .full(bfull),
         .out_valid(out_valid[o]), .out_ready(out_ready[o]),
         .out_src(out_src[o*SRC_W +: SRC_W]),
         .out_payload(out_payload[o*PAY_W +: PAY_W])
      );

      AST_FROZEN_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
         bfull |-> (in_pop & req) == '0);  // R4
   end

   AST_HOL_POP: assert property (@(posedge clk) disable iff (!rst_n) (in_pop & ~hv) == '0);  // R5
endmodule

// File: tb/mem_xbar_bench.sv
module mem_xbar_bench;
   localparam int NI = 4, NO = 4, PW = 16, DW = 2, SW = 2, GAP = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NI-1:0]    in_valid = '0;
   logic [NI-1:0]    in_ready;
   logic [NI*DW-1:0] in_dest = '0;
   logic [NI*PW-1:0] in_payload = '0;
   logic [NO-1:0]    out_valid;
   logic [NO-1:0]    out_ready = '1;
   logic [NO*SW-1:0] out_src;
   logic [NO*PW-1:0] out_payload;

   always #4 clk = ~clk;

   mem_xbar #(.N_IN(NI), .N_OUT(NO), .PAY_W(PW), .FIFO_DEPTH(7), .BUF_DEPTH(7),
              .DRAM_GAP(GAP), .DRAM_MASK(32'hC)) u_mem_xbar (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready), .in_dest(in_dest), .in_payload(in_payload),
      .out_valid(out_valid), .out_ready(out_ready), .out_src(out_src), .out_payload(out_payload)
   );

   int n_chk = 0, n_bad = 0, cyc = 0;
   logic [PW-1:0] expq [NI*NO][$];
   int fire_t [NO][$];
   int fire_s [NO][$];
   int seqn [NI];
   int acc [NI];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic bit is_dram(input int o);
      return (o >= 2);
   endfunction

   // driver: hold the packet until accepted, then record what must come out
   task automatic send(input int s, input int d);
      logic [PW-1:0] p;
      bit ok;
      p = {8'(s), 8'(seqn[s])};
      seqn[s]++;
      in_valid[s] = 1'b1;
      in_dest[s*DW +: DW] = DW'(d);
      in_payload[s*PW +: PW] = p;
      forever begin
         #3;
         ok = in_ready[s];
         if (ok) begin
            expq[s*NO + d].push_back(p);
            acc[s]++;
         end
         @(negedge clk);
         if (ok) break;
      end
      in_valid[s] = 1'b0;
   endtask

   // monitor: compare each handover with the scoreboard
   always begin
      @(negedge clk);
      #3;
      for (int o = 0; o < NO; o++) begin
         if (out_valid[o] && out_ready[o]) begin
            int s;
            logic [PW-1:0] p;
            s = int'(out_src[o*SW +: SW]);
            p = out_payload[o*PW +: PW];
            chk(int'(p[15:8]) == s, "R2", "out_src vs payload source", s, int'(p[15:8]));
            if (expq[s*NO + o].size() == 0) begin
               chk(1'b0, "R2", "unexpected packet on bank", o, -1);
            end else begin
               logic [PW-1:0] e;
               e = expq[s*NO + o].pop_front();
               chk(p == e, "R2", "payload/order", int'(p), int'(e));
            end
            if (is_dram(o) && fire_t[o].size() > 0)
               chk(cyc - fire_t[o][$] >= GAP, "R7", "DRAM handover spacing", cyc - fire_t[o][$], GAP);
            fire_t[o].push_back(cyc);
            fire_s[o].push_back(s);
         end
      end
   end

   function automatic bit all_empty();
      for (int k = 0; k < NI*NO; k++) if (expq[k].size() != 0) return 1'b0;
      return 1'b1;
   endfunction

   task automatic drain();
      do @(negedge clk); while (!all_empty());
      repeat (4) @(negedge clk);
   endtask

   task automatic clear_log();
      for (int o = 0; o < NO; o++) begin
         fire_t[o].delete();
         fire_s[o].delete();
      end
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   int base, done_cnt, tog_on;

   initial begin
      for (int s = 0; s < NI; s++) begin seqn[s] = 0; acc[s] = 0; end
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      #3;
      chk(in_ready == 4'hF, "R8", "in_ready after reset", int'(in_ready), 15);
      chk(out_valid == 4'h0, "R8", "out_valid after reset", int'(out_valid), 0);
      @(negedge clk);

      // R6: SRAM bank streams back to back
      clear_log();
      for (int k = 0; k < 10; k++) send(0, 0);
      drain();
      chk(fire_t[0].size() == 10, "R6", "SRAM handover count", fire_t[0].size(), 10);
      if (fire_t[0].size() == 10)
         chk(fire_t[0][9] - fire_t[0][0] == 9, "R6", "SRAM handover span", fire_t[0][9] - fire_t[0][0], 9);

      // R7: DRAM bank paced at GAP
      clear_log();
      for (int k = 0; k < 4; k++) send(1, 2);
      drain();
      chk(fire_t[2].size() == 4, "R7", "DRAM handover count", fire_t[2].size(), 4);
      if (fire_t[2].size() == 4)
         for (int k = 1; k < 4; k++)
            chk(fire_t[2][k] - fire_t[2][k-1] == GAP, "R7", "DRAM exact gap", fire_t[2][k] - fire_t[2][k-1], GAP);

      // R3: three inputs contend for bank 1
      clear_log();
      done_cnt = 0;
      for (int s = 0; s < 3; s++) begin
         fork
            automatic int ss = s;
            begin
               for (int k = 0; k < 6; k++) send(ss, 1);
               done_cnt++;
            end
         join_none
      end
      wait (done_cnt == 3);
      drain();
      chk(fire_s[1].size() == 18, "R3", "contended handover count", fire_s[1].size(), 18);
      if (fire_s[1].size() == 18)
         for (int k = 0; k < 18; k++)
            chk(fire_s[1][k] == k % 3, "R3", "round-robin winner", fire_s[1][k], k % 3);

      // R1/R4: DRAM bank 3 stalled, input 2 fills both stages
      clear_log();
      out_ready[3] = 1'b0;
      base = acc[2];
      done_cnt = 0;
      fork
         begin
            for (int k = 0; k < 20; k++) send(2, 3);
            done_cnt++;
         end
      join_none
      repeat (40) @(negedge clk);
      #3;
      chk(acc[2] - base == 14, "R4", "packets absorbed with bank stalled", acc[2] - base, 14);
      chk(in_ready[2] == 1'b0, "R1", "in_ready low on full queue", int'(in_ready[2]), 0);
      chk(out_valid[3] == 1'b1, "R4", "stalled bank still offers", int'(out_valid[3]), 1);
      @(negedge clk);

      // R5: head-of-line blocking on input 3, input 0 unaffected
      send(3, 3);
      send(3, 0);
      send(0, 0);
      repeat (20) @(negedge clk);
      chk(fire_t[0].size() == 1, "R5", "bank 0 handovers while input 3 blocked", fire_t[0].size(), 1);
      if (fire_t[0].size() >= 1)
         chk(fire_s[0][0] == 0, "R5", "bank 0 served input 0", fire_s[0][0], 0);
      out_ready[3] = 1'b1;
      wait (done_cnt == 1);
      drain();
      chk(fire_t[0].size() == 2, "R5", "blocked packet released", fire_t[0].size(), 2);
      chk(fire_t[3].size() == 21, "R2", "bank 3 handover count", fire_t[3].size(), 21);

      // R2: mixed traffic from all inputs, SRAM ready toggling
      clear_log();
      done_cnt = 0;
      tog_on = 1;
      fork
         while (tog_on == 1) begin
            out_ready[0] = (cyc % 3) != 0;
            out_ready[1] = (cyc % 2) != 0;
            @(negedge clk);
         end
      join_none
      for (int s = 0; s < NI; s++) begin
         fork
            automatic int ss = s;
            begin
               for (int k = 0; k < 8; k++) send(ss, (ss + k) % NO);
               done_cnt++;
            end
         join_none
      end
      wait (done_cnt == NI);
      drain();
      tog_on = 0;
      @(negedge clk);
      out_ready = '1;
      begin
         int tot;
         tot = 0;
         for (int o = 0; o < NO; o++) tot += fire_t[o].size();
         chk(tot == 32, "R2", "mixed traffic handovers", tot, 32);
      end
      chk(in_ready == 4'hF, "R1", "queues empty at end", int'(in_ready), 15);
      finish_run();
   end
endmodule